// File: doc/BRIEF.md
# Quadrature Move Pulse Generator

One output channel that turns a queued move into a pair of quadrature phases. A move is given as a 24-bit count of quadrature edges plus a configuration: the spacing between edges, the direction, the level that the auxiliary output holds, and the length of an end-of-move marker. The channel copies the configuration into its own registers at the moment it takes the move. It then steps the phases once each time the spacing timer expires, and decrements the move counter on each step until the counter is empty.

The queue in front of the block offers a command with `cmd_valid` and sees `cmd_take` in the cycle the channel accepts it. A command is taken whenever the counter is empty. It is also taken in the same cycle as the last edge of the running move, so a stream of queued moves produces one continuous waveform. The spacing timer runs either on every base clock cycle or on a slow tick, which is an enable pulse every `SLOW_DIV` base cycles. The marker output rises with the final edge of a move and can stay high across the first edges of the move that follows.

Top module: `quad_move_gen`

## Requirements
- R1: With the effective direction up, each edge moves (pha,phb) one step along 00 → 10 → 11 → 01 → 00.
- R2: With the effective direction down, each edge moves (pha,phb) one step along 00 → 01 → 11 → 10 → 00.
- R3: Each edge changes exactly one of pha and phb. A move of count N produces exactly N edges. `cur_count` shows the loaded count and falls by one on each edge, reaching 0 when the move ends.
- R4: With `slow_sel` = 0, consecutive edges of a move whose spacing value is W (W ≥ 1) are exactly W clock cycles apart.
- R5: With `slow_sel` = 1, the spacing timer counts only on the slow tick, so edges of a move with spacing W are W × SLOW_DIV cycles apart (66 cycles for W = 2 at the default of 33).
- R6: The marker code maps 00 = off, 01 = 1 count, 10 = 2 counts and 11 = 4 counts. A nonzero code makes `mark` rise together with the last edge of its move. `mark` then stays high through exactly that many edges in total (the final edge and the first edges of the next move), and falls together with the edge after those. Code 00 never raises `mark`.
- R7: `cmd_take` is high only when `cmd_valid` is high and the counter is either 0 or at its last edge in that cycle. A move queued behind a running one starts with no gap, so its first edge comes one spacing period (of the new move) after the previous move's last edge.
- R8: `aux` takes the aux bit of a command when that command is taken and holds it until the next take or move reset.
- R9: While `chan_en` is 0 no edge is produced and `cur_count` holds. A command can still be taken.
- R10: With `reverse` = 1 the latched direction is inverted, so an up move follows the down sequence of R2.
- R11: A one-cycle `quad_reset` forces pha and phb to 0 on the next clock edge.
- R12: A `move_reset` empties the counter and clears the latched configuration: on the next edge `cur_count` = 0, `at_zero` = 1, `aux` = 0 and `mark` = 0, and no further edges occur.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock, one cycle per base tick |
| rst_n | input | 1 | Synchronous active-low reset |
| chan_en | input | 1 | Channel enable; edges only while high |
| reverse | input | 1 | Inverts the latched direction |
| slow_sel | input | 1 | 0: timer counts every cycle, 1: timer counts on the slow tick |
| quad_reset | input | 1 | Forces both phases low |
| move_reset | input | 1 | Empties the counter and clears the latched configuration |
| cmd_valid | input | 1 | A queued command is offered |
| cmd_count | input | COUNT_W | Edges in the offered move |
| cmd_space | input | 24 | Timer periods between edges |
| cmd_up | input | 1 | Direction, 1 = up |
| cmd_aux | input | 1 | Aux level for the move |
| cmd_mark | input | 2 | Marker length code |
| cmd_take | output | 1 | The offered command is taken this cycle |
| at_zero | output | 1 | Move counter is empty |
| cur_count | output | COUNT_W | Present move counter value |
| pha | output | 1 | Phase A |
| phb | output | 1 | Phase B |
| mark | output | 1 | End-of-move marker |
| aux | output | 1 | Latched aux level |

## Verification
The hardest case to reach from the ports is a marker that has to carry over into the following move. A second command must already be waiting when the first move ends, so that it is taken in the same cycle as the last edge. The bench does this by presenting the second command right after the first is taken and holding it until `cmd_take` appears. It then records, for every edge, the time and the marker level. From that record it checks both the gap-free spacing and the number of edges covered by the marker, for every marker code.

// File: rtl/qmg_pkg.sv
// Shared types for the quadrature move generator.
// Assumes a 24-bit spacing field and a 2-bit marker code.
package qmg_pkg;
    localparam int SPACE_W = 24;

    // Configuration latched with each move
    typedef struct packed {
        logic [SPACE_W-1:0] space;
        logic               up;
        logic               aux;
        logic [1:0]         mark;
    } move_cfg_t;

    // Marker code to the number of further edges M stays high after rising
    function automatic logic [2:0] mark_extra(input logic [1:0] code);
        case (code)
            2'b10:   return 3'd1;
            2'b11:   return 3'd3;
            default: return 3'd0;
        endcase
    endfunction
endpackage

// File: rtl/qmg_tick.sv
// Time base for the spacing timer. It gives either a tick on every cycle
// or a pulse every SLOW_DIV cycles from a free-running divider.
// Assumes SLOW_DIV >= 2.
module qmg_tick #(
    parameter int SLOW_DIV = 33
) (
    input  logic clk,
    input  logic rst_n,
    input  logic slow_sel,
    output logic tick
);
    localparam int DIV_W = $clog2(SLOW_DIV);

    logic [DIV_W-1:0] div_q;
    logic             slow_pulse;

    assign slow_pulse = (div_q == DIV_W'(SLOW_DIV - 1));

    // Free-running divider that wraps every SLOW_DIV cycles
    always_ff @(posedge clk) begin
        if (!rst_n || slow_pulse) div_q <= '0;
        else                      div_q <= div_q + 1'b1;
    end

    assign tick = slow_sel ? slow_pulse : 1'b1;
endmodule

// File: rtl/qmg_spacer.sv
// Spacing timer. It reloads on a move load or on an edge, counts down on
// the tick and fires when it reaches 1. A value of 0 behaves as 1.
// Assumes the load has priority over the reload after an edge.
module qmg_spacer #(
    parameter int W = 24
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic [W-1:0] reload_val,
    input  logic         run,
    input  logic         tick,
    output logic         fire
);
    logic [W-1:0] wcnt_q;

    assign fire = run && tick && (wcnt_q <= W'(1));

    // Spacing counter: load, reload after an edge, or count down
    always_ff @(posedge clk) begin
        if (!rst_n || clr)  wcnt_q <= '0;
        else if (load)      wcnt_q <= load_val;
        else if (fire)      wcnt_q <= reload_val;
        else if (run && tick) wcnt_q <= wcnt_q - 1'b1;
    end
endmodule

// File: rtl/qmg_phase.sv
// Quadrature state and end-of-move marker. The phase index steps up or
// down on each edge. The marker rises on the final edge of a move and
// counts the further edges it must remain high.
// Assumes the index maps 0:00 1:10 2:11 3:01 for (A,B).
module qmg_phase (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       quad_clr,
    input  logic       mark_clr,
    input  logic       step,
    input  logic       up,
    input  logic       finish,
    input  logic [1:0] mark_code,
    output logic       pha,
    output logic       phb,
    output logic       mark
);
    logic [1:0] idx_q;
    logic       mark_q;
    logic [2:0] left_q;

    // Phase index: forced to 0 by quadrature reset, else steps
    always_ff @(posedge clk) begin
        if (!rst_n || quad_clr) idx_q <= 2'd0;
        else if (step)          idx_q <= up ? idx_q + 2'd1 : idx_q - 2'd1;
    end

    // Marker: rise on a finishing edge, then drop after the counted edges
    always_ff @(posedge clk) begin
        if (!rst_n || mark_clr) begin
            mark_q <= 1'b0;
            left_q <= '0;
        end else if (step) begin
            if (finish && mark_code != 2'b00) begin
                mark_q <= 1'b1;
                left_q <= qmg_pkg::mark_extra(mark_code);
            end else if (mark_q) begin
                if (left_q == '0) mark_q <= 1'b0;
                else              left_q <= left_q - 1'b1;
            end
        end
    end

    assign pha  = idx_q[0] ^ idx_q[1];
    assign phb  = idx_q[1];
    assign mark = mark_q;
endmodule

// File: rtl/quad_move_gen.sv
// One quadrature output channel. It takes a move when its counter is empty,
// or on the last edge of the running move, latches the move's
// configuration, and steps the phases each time the spacing timer fires.
// Assumes the queue holds cmd_* stable while cmd_valid is high.
module quad_move_gen #(
    parameter int COUNT_W  = 24,
    parameter int SLOW_DIV = 33
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       chan_en,
    input  logic                       reverse,
    input  logic                       slow_sel,
    input  logic                       quad_reset,
    input  logic                       move_reset,
    input  logic                       cmd_valid,
    input  logic [COUNT_W-1:0]         cmd_count,
    input  logic [qmg_pkg::SPACE_W-1:0] cmd_space,
    input  logic                       cmd_up,
    input  logic                       cmd_aux,
    input  logic [1:0]                 cmd_mark,
    output logic                       cmd_take,
    output logic                       at_zero,
    output logic [COUNT_W-1:0]         cur_count,
    output logic                       pha,
    output logic                       phb,
    output logic                       mark,
    output logic                       aux
);
    import qmg_pkg::*;

    logic [COUNT_W-1:0] count_q;
    move_cfg_t          cfg_q;
    move_cfg_t          cfg_new;
    logic               tick;
    logic               fire;
    logic               last_edge;
    logic               run;

    assign cfg_new   = '{space: cmd_space, up: cmd_up, aux: cmd_aux, mark: cmd_mark};
    assign at_zero   = (count_q == '0);
    assign run       = chan_en && !at_zero;
    assign last_edge = fire && (count_q == COUNT_W'(1));
    assign cmd_take  = cmd_valid && !move_reset && (at_zero || last_edge);

    // Move counter and latched configuration
    always_ff @(posedge clk) begin
        if (!rst_n || move_reset) begin
            count_q <= '0;
            cfg_q   <= '0;
        end else if (cmd_take) begin
            count_q <= cmd_count;
            cfg_q   <= cfg_new;
        end else if (fire) begin
            count_q <= count_q - 1'b1;
        end
    end

    qmg_tick #(.SLOW_DIV(SLOW_DIV)) u_tick (
        .clk      (clk),
        .rst_n    (rst_n),
        .slow_sel (slow_sel),
        .tick     (tick)
    );

    qmg_spacer #(.W(SPACE_W)) u_spacer (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (move_reset),
        .load       (cmd_take),
        .load_val   (cmd_space),
        .reload_val (cfg_q.space),
        .run        (run),
        .tick       (tick),
        .fire       (fire)
    );

    qmg_phase u_phase (
        .clk       (clk),
        .rst_n     (rst_n),
        .quad_clr  (quad_reset),
        .mark_clr  (move_reset),
        .step      (fire),
        .up        (cfg_q.up ^ reverse),
        .finish    (last_edge),
        .mark_code (cfg_q.mark),
        .pha       (pha),
        .phb       (phb),
        .mark      (mark)
    );

    assign cur_count = count_q;
    assign aux       = cfg_q.aux;
endmodule

// File: rtl/qmg_checker.sv
// Port-level properties of the quadrature move generator, bound to the top.
module qmg_checker #(
    parameter int COUNT_W = 24
) (
    input logic               clk,
    input logic               rst_n,
    input logic               chan_en,
    input logic               quad_reset,
    input logic               move_reset,
    input logic               cmd_take,
    input logic [COUNT_W-1:0] cur_count,
    input logic               pha,
    input logic               phb,
    input logic               mark,
    input logic               aux
);
    // R3
    one_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ($countones({pha, phb} ^ $past({pha, phb})) <= 1));

    // R3
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_count > COUNT_W'(1) && !move_reset) |=>
        (cur_count == $past(cur_count) || cur_count == $past(cur_count) - 1'b1));

    // R8
    aux_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmd_take && !move_reset) |=> $stable(aux));

    // R9
    idle_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!chan_en && !quad_reset) |=> $stable({pha, phb}));

    // R11
    quad_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        quad_reset |=> (!pha && !phb));

    // R12
    move_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        move_reset |=> (cur_count == '0 && !aux && !mark));
endmodule

bind quad_move_gen qmg_checker #(.COUNT_W(COUNT_W)) u_qmg_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .chan_en    (chan_en),
    .quad_reset (quad_reset),
    .move_reset (move_reset),
    .cmd_take   (cmd_take),
    .cur_count  (cur_count),
    .pha        (pha),
    .phb        (phb),
    .mark       (mark),
    .aux        (aux)
);

// File: tb/quad_move_gen_bench.sv
// Directed bench for the quadrature move generator. A negedge monitor logs
// every phase change with its cycle and marker level. Scenario tasks drive
// commands and check the log against the requirements.
module quad_move_gen_bench;
    localparam int CLK_PERIOD = 10;
    localparam int COUNT_W    = 24;
    localparam int SLOW_DIV   = 33;
    localparam int MAXE       = 64;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic chan_en = 1'b0;
    logic reverse = 1'b0;
    logic slow_sel = 1'b0;
    logic quad_reset = 1'b0;
    logic move_reset = 1'b0;
    logic cmd_valid = 1'b0;
    logic [COUNT_W-1:0] cmd_count = '0;
    logic [23:0] cmd_space = '0;
    logic cmd_up = 1'b0;
    logic cmd_aux = 1'b0;
    logic [1:0] cmd_mark = 2'b00;
    logic cmd_take, at_zero, pha, phb, mark, aux;
    logic [COUNT_W-1:0] cur_count;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit log_en = 1'b0;
    int ne = 0;
    logic [1:0] e_ab [MAXE];
    int         e_t  [MAXE];
    logic       e_m  [MAXE];
    logic [1:0] prev_ab = 2'b00;

    always #(CLK_PERIOD/2) clk = ~clk;

    quad_move_gen #(.COUNT_W(COUNT_W), .SLOW_DIV(SLOW_DIV)) u_quad_move_gen (
        .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .reverse(reverse),
        .slow_sel(slow_sel), .quad_reset(quad_reset), .move_reset(move_reset),
        .cmd_valid(cmd_valid), .cmd_count(cmd_count), .cmd_space(cmd_space),
        .cmd_up(cmd_up), .cmd_aux(cmd_aux), .cmd_mark(cmd_mark),
        .cmd_take(cmd_take), .at_zero(at_zero), .cur_count(cur_count),
        .pha(pha), .phb(phb), .mark(mark), .aux(aux)
    );

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // Edge logger and watchdog
    always @(negedge clk) begin
        cyc++;
        if (log_en && {pha, phb} != prev_ab && ne < MAXE) begin
            e_ab[ne] = {pha, phb};
            e_t[ne]  = cyc;
            e_m[ne]  = mark;
            ne++;
        end
        prev_ab = {pha, phb};
        if (cyc > 150000) begin
            checks++;
            errors++;
            $display("FAIL watchdog: act=%0d cycles exp<=150000", cyc);
            finish_run();
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    function automatic int ab_idx(input logic [1:0] ab);
        case (ab)
            2'b00:   return 0;
            2'b10:   return 1;
            2'b11:   return 2;
            default: return 3;
        endcase
    endfunction

    function automatic logic [1:0] idx_ab(input int i);
        case (((i % 4) + 4) % 4)
            0:       return 2'b00;
            1:       return 2'b10;
            2:       return 2'b11;
            default: return 2'b01;
        endcase
    endfunction

    task automatic start_log();
        ne = 0;
        log_en = 1'b1;
    endtask

    task automatic issue(input int cnt, input int space, input bit up,
                         input bit ax, input logic [1:0] mk);
        @(negedge clk);
        cmd_count = COUNT_W'(cnt);
        cmd_space = 24'(space);
        cmd_up    = up;
        cmd_aux   = ax;
        cmd_mark  = mk;
        cmd_valid = 1'b1;
        #1;
        while (!cmd_take) @(negedge clk);
        @(posedge clk);
        #1;
        cmd_valid = 1'b0;
    endtask

    task automatic wait_idle(input int limit);
        int n = 0;
        @(negedge clk);
        while (!(at_zero && !cmd_valid) && n < limit) begin
            @(negedge clk);
            n++;
        end
        repeat (3) @(negedge clk);
        log_en = 1'b0;
    endtask

    // Checks the logged edges against the up or down sequence from start
    task automatic check_seq(input int start, input int dir, input string tag);
        int bad = 0;
        for (int k = 0; k < ne; k++) begin
            if (e_ab[k] != idx_ab(start + (k + 1) * dir)) bad++;
        end
        chk(bad == 0, tag, bad, 0);
    endtask

    task automatic check_gaps(input int from, input int gap, input string tag);
        int bad = 0;
        for (int k = from; k < ne; k++) begin
            if (e_t[k] - e_t[k-1] != gap) bad++;
        end
        chk(bad == 0, tag, bad, 0);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk({pha, phb, mark, aux} == 4'b0000, "R11 reset phases", {pha, phb, mark, aux}, 0);
        chk(at_zero && cur_count == '0, "R3 reset counter", cur_count, 0);
    endtask

    task automatic t_up();
        int s = ab_idx({pha, phb});
        start_log();
        issue(8, 1, 1'b1, 1'b1, 2'b00);
        @(negedge clk);
        chk(aux == 1'b1, "R8 aux during move", aux, 1);
        wait_idle(200);
        chk(ne == 8, "R3 edge count up", ne, 8);
        check_seq(s, 1, "R1 up sequence");
        check_gaps(1, 1, "R4 spacing 1");
        chk(cur_count == '0 && !mark, "R3 counter empty", cur_count, 0);
    endtask

    task automatic t_down();
        int s = ab_idx({pha, phb});
        start_log();
        issue(6, 3, 1'b0, 1'b0, 2'b00);
        @(negedge clk);
        chk(aux == 1'b0, "R8 aux new level", aux, 0);
        wait_idle(200);
        chk(ne == 6, "R3 edge count down", ne, 6);
        check_seq(s, -1, "R2 down sequence");
        check_gaps(1, 3, "R4 spacing 3");
    endtask

    task automatic t_slow();
        slow_sel = 1'b1;
        start_log();
        issue(3, 2, 1'b1, 1'b0, 2'b00);
        wait_idle(1000);
        chk(ne == 3, "R5 slow edge count", ne, 3);
        check_gaps(1, 2 * SLOW_DIV, "R5 slow spacing");
        slow_sel = 1'b0;
    endtask

    task automatic t_gapless();
        start_log();
        issue(4, 4, 1'b1, 1'b1, 2'b11);
        issue(10, 4, 1'b1, 1'b0, 2'b00);
        @(negedge clk);
        chk(aux == 1'b0, "R8 aux follows second move", aux, 0);
        wait_idle(500);
        chk(ne == 14, "R7 edge count two moves", ne, 14);
        check_gaps(1, 4, "R7 no gap between moves");
    endtask

    task automatic t_marks();
        int want [4] = '{0, 1, 2, 4};
        for (int c = 0; c < 4; c++) begin
            int hi = 0;
            start_log();
            issue(3, 2, 1'b1, 1'b0, 2'(c));
            issue(5, 2, 1'b1, 1'b0, 2'b00);
            wait_idle(300);
            for (int k = 0; k < ne; k++) if (e_m[k]) hi++;
            chk(hi == want[c], $sformatf("R6 marker edges code %0d", c), hi, want[c]);
            chk(e_m[1] == 1'b0 && e_m[2] == (c != 0), "R6 marker rises on last edge",
                int'(e_m[2]), int'(c != 0));
            chk(mark == 1'b0, "R6 marker low after", mark, 0);
        end
    endtask

    task automatic t_enable();
        chan_en = 1'b0;
        start_log();
        issue(5, 1, 1'b1, 1'b0, 2'b00);
        repeat (40) @(negedge clk);
        chk(ne == 0, "R9 no edges while off", ne, 0);
        chk(cur_count == COUNT_W'(5), "R9 count held while off", cur_count, 5);
        chan_en = 1'b1;
        wait_idle(100);
        chk(ne == 5, "R9 edges after enable", ne, 5);
    endtask

    task automatic t_reverse();
        int s = ab_idx({pha, phb});
        reverse = 1'b1;
        start_log();
        issue(4, 1, 1'b1, 1'b0, 2'b00);
        wait_idle(100);
        reverse = 1'b0;
        chk(ne == 4, "R10 edge count", ne, 4);
        check_seq(s, -1, "R10 reversed up follows down");
    endtask

    task automatic t_quad_reset();
        issue(1, 1, 1'b1, 1'b0, 2'b00);
        wait_idle(20);
        if ({pha, phb} == 2'b00) begin
            issue(1, 1, 1'b1, 1'b0, 2'b00);
            wait_idle(20);
        end
        chk({pha, phb} != 2'b00, "R11 precondition nonzero", {pha, phb}, 1);
        @(negedge clk);
        quad_reset = 1'b1;
        @(negedge clk);
        quad_reset = 1'b0;
        chk({pha, phb} == 2'b00, "R11 phases cleared", {pha, phb}, 0);
    endtask

    task automatic t_move_reset();
        issue(1000, 20, 1'b1, 1'b1, 2'b11);
        repeat (50) @(negedge clk);
        chk(aux == 1'b1 && !at_zero, "R12 precondition busy", aux, 1);
        move_reset = 1'b1;
        @(negedge clk);
        move_reset = 1'b0;
        chk(cur_count == '0 && at_zero, "R12 counter emptied", cur_count, 0);
        chk(aux == 1'b0 && mark == 1'b0, "R12 config cleared", {aux, mark}, 0);
        start_log();
        repeat (60) @(negedge clk);
        log_en = 1'b0;
        chk(ne == 0, "R12 no edges after reset", ne, 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        chan_en = 1'b1;
        t_up();
        t_down();
        t_slow();
        t_gapless();
        t_marks();
        t_enable();
        t_reverse();
        t_quad_reset();
        t_move_reset();
        finish_run();
    end
endmodule